// File: doc/BRIEF.md
# Nibble Stack Sequencer

This block keeps the stack pointer of a small 4-bit controller and moves return state between the core and a nibble-wide data RAM. A call or interrupt entry saves a six-nibble frame: the program counter, padded to sixteen bits, and the 8-bit status word. The frame is written at descending addresses, one nibble per clock. A return reads the frame back in ascending order and rebuilds the program counter. An interrupt return also rebuilds the status word. A single 8-bit register pair can be pushed or popped as two nibbles. Software can load the pointer as one byte.

The stack pointer is always even. Every stack access lands in the lowest 256-nibble bank of the RAM, whatever bank the core is using. Pointer arithmetic wraps modulo 256. A wrap leaves a sticky flag for the core to inspect. While a sequence is running, `busy` is high and new commands are dropped.

Top module: `nib_stack_engine`

## Requirements
- R1: After reset, `sp_out` is 00h, `busy`, `ovf` and `unf` are 0, and neither `mem_we` nor `mem_re` nor any load strobe is asserted.
- R2: Opcode 6 (load) copies `sp_in` into the pointer with bit 0 forced to 0. The new value is visible in the next cycle. The load also clears `ovf` and `unf`.
- R3: Opcodes 0 (call) and 1 (interrupt) write six nibbles on consecutive cycles, starting in the cycle after acceptance. The addresses run SP-1 down to SP-6. The data order is PC[15:12] (bits 15..14 zero), PC[11:8], PC[7:4], PC[3:0], PSW[7:4], PSW[3:0].
- R4: Opcode 2 (return) reads six nibbles at SP, SP+1 … SP+5 on consecutive cycles. `pc_load` pulses for one cycle right after the last read. `pc_out` equals {read6[1:0], read5, read4, read3}.
- R5: Opcode 3 (interrupt return) behaves like return. It also pulses `psw_load` in the same cycle, with `psw_out` = {read2, read1}. A plain return never pulses `psw_load`.
- R6: Opcode 4 (push pair) writes `pair_in[7:4]` at SP-1 and then `pair_in[3:0]` at SP-2.
- R7: Opcode 5 (pop pair) reads SP and then SP+1. `pair_load` pulses after the second read, with `pair_out` = {second read, first read}.
- R8: Every stack access drives `mem_addr[11:8]` to 0. The low byte wraps modulo 256.
- R9: A save that starts with SP below its nibble count sets `ovf`. A restore whose SP plus nibble count exceeds 255 sets `unf`. Both flags stay set until the next load.
- R10: `busy` is high for exactly the nibble count of an accepted sequence. Commands presented while `busy` is high are ignored, and opcode 7 is always ignored.
- R11: `sp_out` holds its value while a sequence runs. It changes once, in the cycle after the last nibble, by minus the count for saves and plus the count for restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 0 call, 1 interrupt, 2 return, 3 interrupt return, 4 push pair, 5 pop pair, 6 load, 7 none |
| pc_in | input | 14 | Program counter to save |
| psw_in | input | 8 | Status word to save |
| pair_in | input | 8 | Register pair to push |
| sp_in | input | 8 | Pointer value for load |
| mem_rdata | input | 4 | RAM read nibble, valid in the same cycle as the address |
| busy | output | 1 | Sequence in progress |
| sp_out | output | 8 | Current stack pointer |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_addr | output | 12 | RAM nibble address |
| mem_wdata | output | 4 | RAM write nibble |
| pc_out | output | 14 | Restored program counter |
| pc_load | output | 1 | One-cycle strobe: `pc_out` valid |
| psw_out | output | 8 | Restored status word |
| psw_load | output | 1 | One-cycle strobe: `psw_out` valid |
| pair_out | output | 8 | Popped register pair |
| pair_load | output | 1 | One-cycle strobe: `pair_out` valid |
| ovf | output | 1 | Sticky downward-wrap flag |
| unf | output | 1 | Sticky upward-wrap flag |

## Verification
Two functions meet in one cycle when a new command arrives in the final nibble cycle of a running sequence, at the same moment the pointer is about to be updated. The bench provokes this in two ways. It holds `cmd_valid` high across whole sequences, and it presents a different opcode while a frame is still in flight. A queue-based reference model decides on each edge whether the command is dropped or accepted. The bench then compares the pointer, the bus and the flags on every cycle, which shows that the last step's pointer update is not disturbed and that the next command starts exactly one cycle after `busy` falls.

// File: rtl/nib_stack_engine.sv
module nib_stack_engine #(
  parameter int SPW  = 8,
  parameter int PCW  = 14,
  parameter int PSWW = 8,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [PCW-1:0]  pc_in,
  input  logic [PSWW-1:0] psw_in,
  input  logic [7:0]      pair_in,
  input  logic [SPW-1:0]  sp_in,
  input  logic [3:0]      mem_rdata,
  output logic            busy,
  output logic [SPW-1:0]  sp_out,
  output logic            mem_we,
  output logic            mem_re,
  output logic [AW-1:0]   mem_addr,
  output logic [3:0]      mem_wdata,
  output logic [PCW-1:0]  pc_out,
  output logic            pc_load,
  output logic [PSWW-1:0] psw_out,
  output logic            psw_load,
  output logic [7:0]      pair_out,
  output logic            pair_load,
  output logic            ovf,
  output logic            unf
);
  localparam int PCPW  = ((PCW + 3) / 4) * 4;
  localparam int FRAME = PCPW / 4 + PSWW / 4;
  localparam int BUFW  = FRAME * 4;
  localparam int LW    = $clog2(FRAME + 1);

  localparam logic [2:0] OP_CALL = 3'd0, OP_INTR = 3'd1, OP_RET = 3'd2, OP_IRET = 3'd3,
                         OP_PUSH = 3'd4, OP_POP  = 3'd5, OP_LOAD = 3'd6;

  logic [SPW-1:1]  sp_q;
  logic            busy_q, save_q;
  logic [2:0]      op_q;
  logic [LW-1:0]   len_q, idx_q;
  logic [BUFW-1:0] buf_q;
  logic            ovf_q, unf_q, pcl_q, psl_q, prl_q;

  wire [SPW-1:0] base   = {sp_q, 1'b0};
  wire           accept = cmd_valid && !busy_q;
  wire           op_pair  = (cmd_op == OP_PUSH) || (cmd_op == OP_POP);
  wire           op_save  = (cmd_op == OP_CALL) || (cmd_op == OP_INTR) || (cmd_op == OP_PUSH);
  wire           op_rest  = (cmd_op == OP_RET) || (cmd_op == OP_IRET) || (cmd_op == OP_POP);
  wire [LW-1:0]  len_new  = op_pair ? LW'(2) : LW'(FRAME);
  wire [SPW-1:0] n_sp     = SPW'(len_new);
  wire [SPW:0]   rest_sum = {1'b0, base} + {1'b0, n_sp};
  wire [SPW-1:0] step_adr = save_q ? base - SPW'(1) - SPW'(idx_q) : base + SPW'(idx_q);
  wire [SPW-1:0] end_sp   = save_q ? base - SPW'(len_q) : base + SPW'(len_q);
  wire           last     = (idx_q == len_q - LW'(1));

  assign busy      = busy_q;
  assign sp_out    = base;
  assign mem_we    = busy_q && save_q;
  assign mem_re    = busy_q && !save_q;
  assign mem_addr  = {{(AW-SPW){1'b0}}, step_adr};
  assign mem_wdata = buf_q[BUFW-1 -: 4];
  assign pc_out    = buf_q[PSWW +: PCW];
  assign psw_out   = buf_q[PSWW-1:0];
  assign pair_out  = buf_q[BUFW-1 -: 8];
  assign pc_load   = pcl_q;
  assign psw_load  = psl_q;
  assign pair_load = prl_q;
  assign ovf       = ovf_q;
  assign unf       = unf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0; busy_q <= 1'b0; save_q <= 1'b0; op_q <= '0;
      len_q <= '0; idx_q <= '0; buf_q <= '0;
      ovf_q <= 1'b0; unf_q <= 1'b0;
      pcl_q <= 1'b0; psl_q <= 1'b0; prl_q <= 1'b0;
    end else begin
      pcl_q <= 1'b0; psl_q <= 1'b0; prl_q <= 1'b0;
      if (accept) begin
        if (cmd_op == OP_LOAD) begin
          sp_q  <= sp_in[SPW-1:1];
          ovf_q <= 1'b0;
          unf_q <= 1'b0;
        end else if (op_save || op_rest) begin
          busy_q <= 1'b1;
          save_q <= op_save;
          op_q   <= cmd_op;
          len_q  <= len_new;
          idx_q  <= '0;
          if (op_save) begin
            buf_q <= op_pair ? {pair_in, {(BUFW-8){1'b0}}}
                             : {{(PCPW-PCW){1'b0}}, pc_in, psw_in};
            ovf_q <= ovf_q || (base < n_sp);
          end else begin
            unf_q <= unf_q || rest_sum[SPW];
          end
        end
      end
      if (busy_q) begin
        idx_q <= idx_q + LW'(1);
        buf_q <= save_q ? {buf_q[BUFW-5:0], 4'h0} : {mem_rdata, buf_q[BUFW-1:4]};
        if (last) begin
          busy_q <= 1'b0;
          sp_q   <= end_sp[SPW-1:1];
          pcl_q  <= (op_q == OP_RET) || (op_q == OP_IRET);
          psl_q  <= (op_q == OP_IRET);
          prl_q  <= (op_q == OP_POP);
        end
      end
    end
  end
endmodule

module nib_stack_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        busy,
  input logic [7:0]  sp_out,
  input logic        mem_we,
  input logic        mem_re,
  input logic [11:0] mem_addr,
  input logic        pc_load,
  input logic        psw_load,
  input logic        ovf,
  input logic        unf
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_we && !mem_re); // R10
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R10
  AST_SAVE_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1); // R3
  AST_REST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && $past(mem_re) |-> mem_addr[7:0] == $past(mem_addr[7:0]) + 8'd1); // R4
  AST_SP_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> $stable(sp_out)); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(cmd_valid && !busy && cmd_op == 3'd6) |=> ovf); // R9
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf && !(cmd_valid && !busy && cmd_op == 3'd6) |=> unf); // R9
  AST_PC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pc_load |=> !pc_load); // R4
  AST_PSW_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n) psw_load |-> pc_load); // R5
endmodule

bind nib_stack_engine nib_stack_engine_chk u_chk (.*);

// File: tb/test_nib_stack_engine.sv
module test_nib_stack_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd7;
  logic [13:0] pc_in = '0;
  logic [7:0] psw_in = '0, pair_in = '0, sp_in = '0;
  logic [3:0] mem_rdata;
  logic busy, mem_we, mem_re, pc_load, psw_load, pair_load, ovf, unf;
  logic [7:0] sp_out, psw_out, pair_out;
  logic [11:0] mem_addr;
  logic [3:0] mem_wdata;
  logic [13:0] pc_out;

  always #10 clk = ~clk;

  nib_stack_engine i_nib_stack_engine (.*);

  logic [3:0] ram [256];
  assign mem_rdata = ram[mem_addr[7:0]];

  int checks = 0, failures = 0;
  int m_sp = 0, m_op = 0;
  bit m_ovf = 0, m_unf = 0, e_pcl = 0, e_psl = 0, e_prl = 0;
  int m_next = 0, e_pc = 0, e_psw = 0, e_pair = 0;
  int wa[$], wd[$], ra[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial for (int i = 0; i < 256; i++) ram[i] = 4'(i * 7 + 3);

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (!rst_n) begin
      m_sp = 0; m_ovf = 0; m_unf = 0; e_pcl = 0; e_psl = 0; e_prl = 0;
      wa.delete(); wd.delete(); ra.delete();
    end else begin
      e_pcl = 0; e_psl = 0; e_prl = 0;
      if (wa.size() > 0) begin
        void'(wa.pop_front()); void'(wd.pop_front());
        if (wa.size() == 0) m_sp = m_next;
      end else if (ra.size() > 0) begin
        void'(ra.pop_front());
        if (ra.size() == 0) begin
          m_sp = m_next;
          e_pcl = (m_op == 2 || m_op == 3);
          e_psl = (m_op == 3);
          e_prl = (m_op == 5);
        end
      end else if (cmd_valid) begin
        int n, sv[$];
        m_op = cmd_op;
        n = (m_op == 4 || m_op == 5) ? 2 : 6;
        if (m_op == 6) begin
          m_sp = sp_in & 8'hFE; m_ovf = 0; m_unf = 0;
        end else if (m_op == 0 || m_op == 1 || m_op == 4) begin
          if (m_op == 4) sv = '{pair_in[7:4], pair_in[3:0]};
          else sv = '{{2'b00, pc_in[13:12]}, pc_in[11:8], pc_in[7:4], pc_in[3:0], psw_in[7:4], psw_in[3:0]};
          for (int i = 0; i < n; i++) begin wa.push_back((m_sp - 1 - i) & 255); wd.push_back(sv[i]); end
          if (m_sp < n) m_ovf = 1;
          m_next = (m_sp - n) & 255;
        end else if (m_op == 2 || m_op == 3 || m_op == 5) begin
          int r[6];
          for (int i = 0; i < n; i++) begin ra.push_back((m_sp + i) & 255); r[i] = ram[(m_sp + i) & 255]; end
          if (m_sp + n > 255) m_unf = 1;
          m_next = (m_sp + n) & 255;
          e_pair = {r[1][3:0], r[0][3:0]};
          e_psw  = {r[1][3:0], r[0][3:0]};
          e_pc   = {r[5][1:0], r[4][3:0], r[3][3:0], r[2][3:0]};
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    string tw, tr;
    tw = (m_op == 4) ? "R6" : "R3";
    tr = (m_op == 5) ? "R7" : (m_op == 3) ? "R5" : "R4";
    chk(busy == (wa.size() > 0 || ra.size() > 0), "R10 busy", busy, (wa.size() > 0 || ra.size() > 0));
    chk(sp_out == m_sp, "R11 sp_out", sp_out, m_sp);
    chk(mem_we == (wa.size() > 0), {tw, " mem_we"}, mem_we, wa.size() > 0);
    if (wa.size() > 0) begin
      chk(mem_addr[7:0] == wa[0], {tw, " write addr"}, mem_addr[7:0], wa[0]);
      chk(mem_wdata == wd[0], {tw, " write data"}, mem_wdata, wd[0]);
    end
    chk(mem_re == (ra.size() > 0), {tr, " mem_re"}, mem_re, ra.size() > 0);
    if (ra.size() > 0) chk(mem_addr[7:0] == ra[0], {tr, " read addr"}, mem_addr[7:0], ra[0]);
    if (mem_we || mem_re) chk(mem_addr[11:8] == 0, "R8 bank", mem_addr[11:8], 0);
    chk(ovf == m_ovf, "R9 ovf", ovf, m_ovf);
    chk(unf == m_unf, "R9 unf", unf, m_unf);
    chk(pc_load == e_pcl, "R4 pc_load", pc_load, e_pcl);
    if (e_pcl) chk(pc_out == e_pc, "R4 pc_out", pc_out, e_pc);
    chk(psw_load == e_psl, "R5 psw_load", psw_load, e_psl);
    if (e_psl) chk(psw_out == e_psw, "R5 psw_out", psw_out, e_psw);
    chk(pair_load == e_prl, "R7 pair_load", pair_load, e_prl);
    if (e_prl) chk(pair_out == e_pair, "R7 pair_out", pair_out, e_pair);
  end

  task automatic hold(input int op, input int cycles);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op);
    repeat (cycles) @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  task automatic idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_out == 0 && !busy && !ovf && !unf && !mem_we && !mem_re && !pc_load, "R1 reset state", sp_out, 0);
    sp_in = 8'h35; hold(6, 1);
    chk(sp_out == 8'h34, "R2 load forces bit0", sp_out, 8'h34);
    sp_in = 8'h00; hold(6, 1);
    pc_in = 14'h2ABC; psw_in = 8'h5A; hold(0, 1); idle();
    chk(ovf == 1 && sp_out == 8'hFA, "R9 call from 00 wraps", sp_out, 8'hFA);
    pair_in = 8'hC3; hold(4, 1); idle();
    hold(5, 1); idle();
    hold(3, 1); idle();
    chk(unf == 1 && sp_out == 8'h00, "R9 iret wraps up", sp_out, 8'h00);
    sp_in = 8'h81; hold(6, 1);
    chk(!ovf && !unf, "R2 load clears flags", {ovf, unf}, 0);
    pc_in = 14'h3FFF; psw_in = 8'hE1; hold(1, 1); idle();
    hold(2, 1); idle();
    pc_in = 14'h1357; hold(0, 1);
    cmd_op = 3'd5; cmd_valid = 1'b1;
    repeat (4) @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
    idle();
    hold(7, 5);
    chk(sp_out == 8'h7A, "R10 opcode 7 ignored", sp_out, 8'h7A);
    hold(3, 1); idle();
    pair_in = 8'h96; hold(4, 9); idle();
    hold(5, 7); idle();
    pc_in = 14'h0421; psw_in = 8'h3C; hold(0, 14); idle();
    sp_in = 8'hFC; hold(6, 1);
    hold(2, 1); idle();
    chk(unf == 1, "R9 return past top", unf, 1);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule